// File: doc/BRIEF.md
# Single-Read-Port Register Access Scheduler

This block is the control for one issue slot whose register-file read path has a single port instead of two. For each instruction that issues, it works out how many register-file reads are needed. Sources that are absent, that name the hard-wired zero register, that repeat the other source, or that are fed from a producer issued in the previous cycle need no read. When two reads remain, the block runs them through the port on two consecutive cycles and raises a flag in the issue cycle. The scheduler then knows ahead of time that the instruction takes one extra cycle.

The slot does not accept an instruction in the cycle that follows a two-read issue, because the port is busy with the second read. The destination broadcast that wakes dependants is delayed by the same amount. An unflagged instruction broadcasts one cycle after issue, and a flagged one broadcasts two cycles after issue. The bypass test is deliberately conservative. Only destinations that any slot issued in the immediately preceding cycle count as bypassed. Every older producer is charged a read.

Top module: `rd_port_seq`

## Requirements
- R1: A source with its valid bit low, or naming register 0, never drives the read port. When no source needs a read, `port_en` stays low and `port_idx` reads 0.
- R2: When both sources are valid and name the same register, at most one read is made, and `two_cycle` stays low.
- R3: A source whose register matches a valid, nonzero destination presented on `prod_vld`/`prod_idx` in the immediately preceding cycle is treated as bypassed, and it is not read.
- R4: When both sources need a read, `two_cycle` is high in the issue cycle. The port reads source A in that cycle and source B in the following cycle.
- R5: In the cycle after a two-read issue, `iss_rdy` is low. An instruction offered in that cycle is ignored: it causes no read and no wakeup, and `iss_rdy` returns high the cycle after.
- R6: An accepted instruction with `dst_vld` high raises `wake_vld` with its `dst_idx` one cycle after issue when `two_cycle` was low, and two cycles after issue when it was high. With `dst_vld` low it raises no wakeup.
- R7: After reset, `iss_rdy` is high and `port_en` and `wake_vld` are low.
- R8: A producer issued two or more cycles before the consumer does not count as bypassed, so its register is still read.
- R9: When exactly one source needs a read, the port reads that source in the issue cycle and `two_cycle` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 1 | Instruction offered to the slot this cycle |
| iss_rdy | output | 1 | Slot can accept an instruction this cycle |
| src_a_vld | input | 1 | Source A present |
| src_a_idx | input | 6 | Source A register number |
| src_b_vld | input | 1 | Source B present |
| src_b_idx | input | 6 | Source B register number |
| dst_vld | input | 1 | Instruction writes a destination |
| dst_idx | input | 6 | Destination register number |
| prod_vld | input | 4 | Per-slot valid for destinations issued this cycle |
| prod_idx | input | 24 | Per-slot destination numbers issued this cycle, slot n at bits 6n+5:6n |
| port_en | output | 1 | Read port active this cycle |
| port_idx | output | 6 | Register read by the port this cycle |
| two_cycle | output | 1 | Accepted instruction needs two sequential reads |
| wake_vld | output | 1 | Dependant wakeup broadcast valid |
| wake_idx | output | 6 | Register number being broadcast |

## Verification
On every cycle, the embedded properties check four things. The port never addresses the zero register. A flagged issue is followed by a busy slot that reads source B and then frees itself. Unflagged wakeups come exactly one cycle after issue. The decisions that depend on which sources count as needed can only be shown by the bench's scenarios: the bypass window limited to one cycle, duplicate and zero-register suppression, and which source the port picks. The same holds for the ignored offer during the busy cycle and for the two-cycle wakeup delay.

// File: rtl/rd_port_seq.sv
module rd_port_seq #(
  parameter int SLOTS = 4,
  parameter int IDX_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   iss_vld,
  output logic                   iss_rdy,
  input  logic                   src_a_vld,
  input  logic [IDX_W-1:0]       src_a_idx,
  input  logic                   src_b_vld,
  input  logic [IDX_W-1:0]       src_b_idx,
  input  logic                   dst_vld,
  input  logic [IDX_W-1:0]       dst_idx,
  input  logic [SLOTS-1:0]       prod_vld,
  input  logic [SLOTS*IDX_W-1:0] prod_idx,
  output logic                   port_en,
  output logic [IDX_W-1:0]       port_idx,
  output logic                   two_cycle,
  output logic                   wake_vld,
  output logic [IDX_W-1:0]       wake_idx
);

  localparam logic [IDX_W-1:0] ZREG = '0;

  logic [SLOTS-1:0]       last_vld;
  logic [SLOTS*IDX_W-1:0] last_idx;
  logic [SLOTS-1:0]       hit_a, hit_b;
  logic                   byp_a, byp_b;
  logic                   need_a, need_b;
  logic                   accept;
  logic                   pend;
  logic [IDX_W-1:0]       pend_idx;
  logic                   s1_vld, s1_slow, s2_vld;
  logic [IDX_W-1:0]       s1_idx, s2_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_vld <= '0;
      last_idx <= '0;
    end else begin
      last_vld <= prod_vld;
      last_idx <= prod_idx;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    wire [IDX_W-1:0] tag = last_idx[s*IDX_W +: IDX_W];
    wire             live = last_vld[s] && (tag != ZREG);
    assign hit_a[s] = live && (tag == src_a_idx);
    assign hit_b[s] = live && (tag == src_b_idx);
  end

  assign byp_a  = |hit_a;
  assign byp_b  = |hit_b;
  assign iss_rdy = !pend;
  assign accept = iss_vld && iss_rdy;

  assign need_a = src_a_vld && (src_a_idx != ZREG) && !byp_a;
  assign need_b = src_b_vld && (src_b_idx != ZREG) && !byp_b &&
                  !(src_a_vld && (src_a_idx == src_b_idx));

  assign two_cycle = accept && need_a && need_b;
  assign port_en   = pend || (accept && (need_a || need_b));

  always_comb begin
    if (pend)                  port_idx = pend_idx;
    else if (accept && need_a) port_idx = src_a_idx;
    else if (accept && need_b) port_idx = src_b_idx;
    else                       port_idx = ZREG;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      pend_idx <= '0;
    end else begin
      pend     <= two_cycle;
      pend_idx <= two_cycle ? src_b_idx : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_slow <= 1'b0;
      s1_idx  <= '0;
      s2_vld  <= 1'b0;
      s2_idx  <= '0;
    end else begin
      s1_vld  <= accept && dst_vld;
      s1_slow <= two_cycle;
      s1_idx  <= dst_idx;
      s2_vld  <= s1_vld && s1_slow;
      s2_idx  <= s1_idx;
    end
  end

  assign wake_vld = s2_vld || (s1_vld && !s1_slow);
  assign wake_idx = s2_vld ? s2_idx : (wake_vld ? s1_idx : ZREG);

  // R1
  no_zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |-> port_idx != ZREG);

  // R4
  second_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    two_cycle |=> (port_en && port_idx == $past(src_b_idx)));

  // R5
  slot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    two_cycle |=> !iss_rdy);

  // R5
  slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_rdy |=> iss_rdy);

  // R6
  fast_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !two_cycle && dst_vld) |=> (wake_vld && wake_idx == $past(dst_idx)));

endmodule

// File: tb/test_rd_port_seq.sv
module test_rd_port_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_vld = 1'b0;
  logic        iss_rdy;
  logic        src_a_vld = 1'b0, src_b_vld = 1'b0, dst_vld = 1'b0;
  logic [5:0]  src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
  logic [3:0]  prod_vld = '0;
  logic [23:0] prod_idx = '0;
  logic        port_en, two_cycle, wake_vld;
  logic [5:0]  port_idx, wake_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rd_port_seq i_rd_port_seq (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_rdy(iss_rdy),
    .src_a_vld(src_a_vld), .src_a_idx(src_a_idx),
    .src_b_vld(src_b_vld), .src_b_idx(src_b_idx),
    .dst_vld(dst_vld), .dst_idx(dst_idx),
    .prod_vld(prod_vld), .prod_idx(prod_idx),
    .port_en(port_en), .port_idx(port_idx), .two_cycle(two_cycle),
    .wake_vld(wake_vld), .wake_idx(wake_idx));

  // fields: av a bv b pv p | exp_en exp_idx exp_two
  localparam int NV = 11;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 6'd5,  1'b1, 6'd7,  1'b0, 6'd0,  1'b1, 6'd5,  1'b1},  // R4
    {1'b1, 6'd0,  1'b1, 6'd7,  1'b0, 6'd0,  1'b1, 6'd7,  1'b0},  // R1 R9
    {1'b1, 6'd5,  1'b0, 6'd9,  1'b0, 6'd0,  1'b1, 6'd5,  1'b0},  // R1 R9
    {1'b1, 6'd12, 1'b1, 6'd12, 1'b0, 6'd0,  1'b1, 6'd12, 1'b0},  // R2
    {1'b1, 6'd3,  1'b1, 6'd4,  1'b1, 6'd3,  1'b1, 6'd4,  1'b0},  // R3
    {1'b1, 6'd3,  1'b1, 6'd4,  1'b1, 6'd4,  1'b1, 6'd3,  1'b0},  // R3
    {1'b1, 6'd0,  1'b1, 6'd0,  1'b0, 6'd0,  1'b0, 6'd0,  1'b0},  // R1
    {1'b0, 6'd8,  1'b0, 6'd9,  1'b0, 6'd0,  1'b0, 6'd0,  1'b0},  // R1
    {1'b1, 6'd63, 1'b1, 6'd1,  1'b0, 6'd0,  1'b1, 6'd63, 1'b1},  // R4
    {1'b1, 6'd2,  1'b1, 6'd0,  1'b1, 6'd2,  1'b0, 6'd0,  1'b0},  // R1 R3
    {1'b1, 6'd6,  1'b1, 6'd6,  1'b1, 6'd6,  1'b0, 6'd0,  1'b0}   // R2 R3
  };

  task automatic check(input bit ok, input string req, input string msg, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, msg, act, exp);
    end
  endtask

  task automatic offer(input bit av, input logic [5:0] a, input bit bv, input logic [5:0] b,
                       input bit dv, input logic [5:0] d);
    iss_vld = 1'b1; src_a_vld = av; src_a_idx = a; src_b_vld = bv; src_b_idx = b;
    dst_vld = dv; dst_idx = d;
  endtask

  task automatic idle();
    iss_vld = 1'b0; src_a_vld = 1'b0; src_b_vld = 1'b0; dst_vld = 1'b0;
    prod_vld = '0; prod_idx = '0;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R7
    check(iss_rdy == 1'b1, "R7", "iss_rdy after reset", iss_rdy, 1);
    check(port_en == 1'b0, "R7", "port_en after reset", port_en, 0);
    check(wake_vld == 1'b0, "R7", "wake_vld after reset", wake_vld, 0);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      @(negedge clk);
      idle();
      prod_vld[2] = v[14];
      prod_idx[17:12] = v[13:8];
      @(negedge clk);
      prod_vld = '0; prod_idx = '0;
      offer(v[28], v[27:22], v[21], v[20:15], 1'b0, 6'd0);
      #1;
      check(port_en == v[7], "R1-R4/R9", $sformatf("vec %0d port_en", i), port_en, v[7]);
      check(port_idx == v[6:1], "R1-R4/R9", $sformatf("vec %0d port_idx", i), port_idx, v[6:1]);
      check(two_cycle == v[0], "R2/R4", $sformatf("vec %0d two_cycle", i), two_cycle, v[0]);
      @(negedge clk);
      idle();
      #1;
      if (v[0]) begin
        // R4 R5
        check(port_en && port_idx == v[20:15], "R4", $sformatf("vec %0d second read", i), port_idx, v[20:15]);
        check(iss_rdy == 1'b0, "R5", $sformatf("vec %0d busy", i), iss_rdy, 0);
      end else begin
        check(port_en == 1'b0, "R1", $sformatf("vec %0d port idle after", i), port_en, 0);
      end
    end

    // R6 fast wakeup
    @(negedge clk); idle();
    @(negedge clk);
    offer(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 6'd20);
    @(negedge clk); idle(); #1;
    check(wake_vld && wake_idx == 6'd20, "R6", "fast wake idx", wake_idx, 20);
    @(negedge clk); #1;
    check(wake_vld == 1'b0, "R6", "fast wake single pulse", wake_vld, 0);

    // R6 slow wakeup and R5 ignored offer
    offer(1'b1, 6'd5, 1'b1, 6'd6, 1'b1, 6'd21);
    #1;
    check(two_cycle == 1'b1, "R4", "slow issue flag", two_cycle, 1);
    @(negedge clk);
    offer(1'b0, 6'd0, 1'b1, 6'd33, 1'b1, 6'd30);
    #1;
    check(iss_rdy == 1'b0, "R5", "slot busy", iss_rdy, 0);
    check(port_idx == 6'd6, "R5", "busy cycle reads B not offer", port_idx, 6);
    check(wake_vld == 1'b0, "R6", "no wake one cycle after flagged", wake_vld, 0);
    @(negedge clk); idle(); #1;
    check(wake_vld && wake_idx == 6'd21, "R6", "slow wake idx", wake_idx, 21);
    check(port_en == 1'b0, "R5", "ignored offer caused no read", port_en, 0);
    check(iss_rdy == 1'b1, "R5", "slot free again", iss_rdy, 1);
    @(negedge clk); #1;
    check(wake_vld == 1'b0, "R5", "ignored offer caused no wake", wake_vld, 0);

    // R6 no destination
    offer(1'b1, 6'd7, 1'b0, 6'd0, 1'b0, 6'd22);
    @(negedge clk); idle(); #1;
    check(wake_vld == 1'b0, "R6", "no dst no wake", wake_vld, 0);

    // R8 producer two cycles back
    @(negedge clk);
    prod_vld[0] = 1'b1; prod_idx[5:0] = 6'd9;
    @(negedge clk); idle();
    @(negedge clk);
    offer(1'b1, 6'd9, 1'b1, 6'd10, 1'b0, 6'd0);
    #1;
    check(two_cycle == 1'b1, "R8", "stale producer still read", two_cycle, 1);
    check(port_idx == 6'd9, "R8", "stale producer port idx", port_idx, 9);
    @(negedge clk); idle();
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule